// File: doc/BRIEF.md
# Multicart Outer Bank Supervisor

This block is the outer-bank controller of a multi-game cartridge. After power-up it is unlocked. In that state, every CPU write into the 0x5000–0x5FFF window lands in one of eight 8-bit configuration registers, and the program area at 0x8000–0xFFFF is handed to a flash device. A fixed boot layout of 8 KiB program slots applies there, and the picture bank is taken straight from the configuration.

A write to register 0 with bit 7 set freezes the whole configuration. From that write on, the window is ordinary cartridge space and no longer reaches the registers. The block then passes a mode index to an inner mapper, which is outside this block. It also supplies program and picture AND masks and OR values. The final bank numbers merge the inner mapper's bank with the outer value, one bit at a time. Only reset unlocks the block again.

The board variant is a static input. It changes the boot layout and the polarity of the program mask.

Top module: `outer_bank_supervisor`

## Requirements
- R1: Reset clears all eight registers. The outputs then show: unlocked, program OR value 0, picture OR value 0, picture mask 0xFF, program mask 0x00FF (outside variant 2), horizontal mirroring, picture RAM writable.
- R2: While unlocked, a write with cpuAddr[15:12] = 0x5 stores cpuData into register cpuAddr[2:0]. The new value is visible on the outputs in the next cycle. Writes with any other top nibble change no register.
- R3: Writing register 0 with bit 7 set locks the block. Once locked, no write changes any register until reset. Writes to register 0 with bit 7 clear keep the block unlocked.
- R4: modeIdx is {variant, register 0 bits [4:0]}.
- R5: prgAndMask has its upper byte 0. Its lower byte is the inverse of register 3, or register 3 unchanged when variant = 2.
- R6: prgOrVal is {register 2, register 1}.
- R7: chrAndMask bits [7:5] are the inverse of register 4 bits [5:3], and bits [4:0] are all 1. chrOrVal is register 6.
- R8: chrRamWe is 1 exactly when register 5 bit 2 is 0.
- R9: While unlocked, prgBank for slot cpuAddr[14:13] = 0, 1, 2, 3 is prgOrVal, prgOrVal+1 (mod 2^16), 0x3E, 0x3F. When variant = 3, slots 2 and 3 give 0x1E and 0x1F instead.
- R10: While unlocked, chrBank equals chrOrVal, and mirrorVert equals register 4 bit 0 (1 = vertical).
- R11: flashSel is 1 exactly when the block is unlocked, cpuAddr[15] is 1, and cpuRead or cpuWrite is 1.
- R12: While locked, each bank is computed with s equal to the matching shift input (innerPrgShift for program, innerChrShift for picture), and m equal to the mask shifted right by s. The bank is (inner bank AND m) OR ((OR value shifted right by s) AND NOT m).
- R13: While locked, mirrorVert follows innerMirrorVert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| variant | input | 3 | Static board variant number |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | CPU write strobe, one cycle per write |
| cpuRead | input | 1 | CPU read strobe |
| innerPrgBank | input | 16 | Program bank from the inner mapper |
| innerPrgShift | input | 2 | Program mask shift for the inner bank unit |
| innerChrBank | input | 8 | Picture bank from the inner mapper |
| innerChrShift | input | 2 | Picture mask shift for the inner bank unit |
| innerMirrorVert | input | 1 | Mirroring from the inner mapper |
| locked | output | 1 | Configuration frozen |
| modeIdx | output | 8 | Inner mapper mode index |
| prgAndMask | output | 16 | Program AND mask |
| prgOrVal | output | 16 | Program OR value |
| chrAndMask | output | 8 | Picture AND mask |
| chrOrVal | output | 8 | Picture OR value |
| prgBank | output | 16 | Final program bank for the current address |
| chrBank | output | 8 | Final picture bank |
| mirrorVert | output | 1 | 1 = vertical, 0 = horizontal mirroring |
| chrRamWe | output | 1 | Picture RAM write enable |
| flashSel | output | 1 | Flash device select |

## Verification
Register writes are sent to addresses that differ in their middle bits but share the 0x5 top nibble. Writes just below and above the window, at 0x4xxx and 0x6xxx, show whether the decode uses only the top nibble. The program OR value 0x12FF is chosen so that slot 1 must carry into the upper byte. Variants 0, 2 and 3 each separate the mask polarity and the boot constants.

After the lock, all four shift values are tried with inner banks whose bits differ from the OR values. This shows whether each bit comes from the inner or the outer source. Late writes that try to unlock the block, or to change its registers, must leave every output unchanged.

// File: rtl/obs_pkg.sv
package obs_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [REG_IDX_W-1:0] idx;
    logic [DATA_W-1:0]    data;
  } regStrobe_t;
endpackage

// File: rtl/obs_ctrl.sv
module obs_ctrl
  import obs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter logic [3:0] WIN_NIBBLE = 4'h5
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWrite,
  input  logic              cpuRead,
  input  logic              locked,
  output regStrobe_t        strobe,
  output logic              flashSel
);
  localparam int TOP = ADDR_W - 1;

  logic inWindow;
  logic inProgram;
  logic unusedAddrBits;

  assign inWindow  = (cpuAddr[TOP -: 4] == WIN_NIBBLE);
  assign inProgram = cpuAddr[TOP];
  assign unusedAddrBits = ^cpuAddr[TOP-4:REG_IDX_W];

  always_comb begin
    strobe.wrEn = cpuWrite && !locked && inWindow;
    strobe.idx  = cpuAddr[REG_IDX_W-1:0];
    strobe.data = cpuData;
  end

  assign flashSel = !locked && inProgram && (cpuRead || cpuWrite);
endmodule

// File: rtl/obs_datapath.sv
module obs_datapath
  import obs_pkg::*;
#(
  parameter int PRG_W     = 16,
  parameter int CHR_W     = 8,
  parameter int VARIANT_W = 3,
  parameter int SHIFT_W   = 2,
  parameter logic [VARIANT_W-1:0] VARIANT_RAW_MASK  = 3'd2,
  parameter logic [VARIANT_W-1:0] VARIANT_SMALL_BOOT = 3'd3,
  parameter logic [PRG_W-1:0] BOOT_BASE_LARGE = 16'h003E,
  parameter logic [PRG_W-1:0] BOOT_BASE_SMALL = 16'h001E
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t                strobe,
  input  logic [VARIANT_W-1:0]      variant,
  input  logic [1:0]                slot,
  input  logic [PRG_W-1:0]          innerPrgBank,
  input  logic [SHIFT_W-1:0]        innerPrgShift,
  input  logic [CHR_W-1:0]          innerChrBank,
  input  logic [SHIFT_W-1:0]        innerChrShift,
  input  logic                      innerMirrorVert,
  output logic                      locked,
  output logic [VARIANT_W+4:0]      modeIdx,
  output logic [PRG_W-1:0]          prgAndMask,
  output logic [PRG_W-1:0]          prgOrVal,
  output logic [CHR_W-1:0]          chrAndMask,
  output logic [CHR_W-1:0]          chrOrVal,
  output logic [PRG_W-1:0]          prgBank,
  output logic [CHR_W-1:0]          chrBank,
  output logic                      mirrorVert,
  output logic                      chrRamWe
);
  localparam int MODE_W   = 5;
  localparam int LOCK_BIT = DATA_W - 1;
  localparam int R_MODE = 0, R_PRG_LO = 1, R_PRG_HI = 2, R_PRG_MASK = 3;
  localparam int R_CHR_CTL = 4, R_MEM_CTL = 5, R_CHR_OR = 6, R_SPARE = 7;

  logic [DATA_W-1:0] cfgReg [NUM_REGS];

  // Register file, one generated slice per register
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgReg[i] <= '0;
      else if (strobe.wrEn && strobe.idx == REG_IDX_W'(i))
        cfgReg[i] <= strobe.data;
    end
  end

  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfgReg[R_SPARE], cfgReg[R_MEM_CTL][7:3],
                           cfgReg[R_MEM_CTL][1:0], cfgReg[R_CHR_CTL][7:6],
                           cfgReg[R_CHR_CTL][2:1], cfgReg[R_MODE][6:5]};

  assign locked  = cfgReg[R_MODE][LOCK_BIT];
  assign modeIdx = {variant, cfgReg[R_MODE][MODE_W-1:0]};

  // Window masks and outer values
  logic [DATA_W-1:0] prgMaskByte;
  assign prgMaskByte = (variant == VARIANT_RAW_MASK) ? cfgReg[R_PRG_MASK]
                                                     : ~cfgReg[R_PRG_MASK];
  assign prgAndMask = PRG_W'(prgMaskByte);
  assign prgOrVal   = {cfgReg[R_PRG_HI], cfgReg[R_PRG_LO]};
  assign chrAndMask = {~cfgReg[R_CHR_CTL][5:3], {(CHR_W-3){1'b1}}};
  assign chrOrVal   = cfgReg[R_CHR_OR];
  assign chrRamWe   = !cfgReg[R_MEM_CTL][2];

  // Boot layout while unlocked
  logic [PRG_W-1:0] bootBase;
  logic [PRG_W-1:0] bootBank;
  assign bootBase = (variant == VARIANT_SMALL_BOOT) ? BOOT_BASE_SMALL
                                                    : BOOT_BASE_LARGE;
  always_comb begin
    unique case (slot)
      2'd0:    bootBank = prgOrVal;
      2'd1:    bootBank = prgOrVal + PRG_W'(1);
      2'd2:    bootBank = bootBase;
      default: bootBank = bootBase + PRG_W'(1);
    endcase
  end

  // Inner/outer merge while locked
  logic [PRG_W-1:0] prgMaskSh, prgOrSh, prgMerged;
  logic [CHR_W-1:0] chrMaskSh, chrOrSh, chrMerged;
  assign prgMaskSh = prgAndMask >> innerPrgShift;
  assign prgOrSh   = prgOrVal   >> innerPrgShift;
  assign prgMerged = (innerPrgBank & prgMaskSh) | (prgOrSh & ~prgMaskSh);
  assign chrMaskSh = chrAndMask >> innerChrShift;
  assign chrOrSh   = chrOrVal   >> innerChrShift;
  assign chrMerged = (innerChrBank & chrMaskSh) | (chrOrSh & ~chrMaskSh);

  assign prgBank    = locked ? prgMerged : bootBank;
  assign chrBank    = locked ? chrMerged : chrOrVal;
  assign mirrorVert = locked ? innerMirrorVert : cfgReg[R_CHR_CTL][0];
endmodule

// File: rtl/outer_bank_supervisor.sv
module outer_bank_supervisor
  import obs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PRG_W     = 16,
  parameter int CHR_W     = 8,
  parameter int VARIANT_W = 3,
  parameter int SHIFT_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VARIANT_W-1:0] variant,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [DATA_W-1:0]    cpuData,
  input  logic                 cpuWrite,
  input  logic                 cpuRead,
  input  logic [PRG_W-1:0]     innerPrgBank,
  input  logic [SHIFT_W-1:0]   innerPrgShift,
  input  logic [CHR_W-1:0]     innerChrBank,
  input  logic [SHIFT_W-1:0]   innerChrShift,
  input  logic                 innerMirrorVert,
  output logic                 locked,
  output logic [VARIANT_W+4:0] modeIdx,
  output logic [PRG_W-1:0]     prgAndMask,
  output logic [PRG_W-1:0]     prgOrVal,
  output logic [CHR_W-1:0]     chrAndMask,
  output logic [CHR_W-1:0]     chrOrVal,
  output logic [PRG_W-1:0]     prgBank,
  output logic [CHR_W-1:0]     chrBank,
  output logic                 mirrorVert,
  output logic                 chrRamWe,
  output logic                 flashSel
);
  regStrobe_t strobe;

  obs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .cpuWrite(cpuWrite),
    .cpuRead (cpuRead),
    .locked  (locked),
    .strobe  (strobe),
    .flashSel(flashSel)
  );

  obs_datapath #(
    .PRG_W(PRG_W), .CHR_W(CHR_W), .VARIANT_W(VARIANT_W), .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .variant        (variant),
    .slot           (cpuAddr[ADDR_W-2 -: 2]),
    .innerPrgBank   (innerPrgBank),
    .innerPrgShift  (innerPrgShift),
    .innerChrBank   (innerChrBank),
    .innerChrShift  (innerChrShift),
    .innerMirrorVert(innerMirrorVert),
    .locked         (locked),
    .modeIdx        (modeIdx),
    .prgAndMask     (prgAndMask),
    .prgOrVal       (prgOrVal),
    .chrAndMask     (chrAndMask),
    .chrOrVal       (chrOrVal),
    .prgBank        (prgBank),
    .chrBank        (chrBank),
    .mirrorVert     (mirrorVert),
    .chrRamWe       (chrRamWe)
  );
endmodule

// File: rtl/obs_checker.sv
module obs_checker #(
  parameter int ADDR_W = 16,
  parameter int PRG_W  = 16,
  parameter int CHR_W  = 8,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              locked,
  input logic [MODE_W-1:0] modeIdx,
  input logic [PRG_W-1:0]  prgAndMask,
  input logic [PRG_W-1:0]  prgOrVal,
  input logic [CHR_W-1:0]  chrOrVal,
  input logic [CHR_W-1:0]  chrBank,
  input logic              flashSel
);
  // R3: lock is sticky until reset
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R3: configuration frozen while locked
  a_r3_config_frozen: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(prgOrVal) && $stable(chrOrVal) && $stable(modeIdx[4:0])
                && $stable(prgAndMask)));

  // R11: flash selected only while unlocked and in program space
  a_r11_flash_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    flashSel |-> (!locked && cpuAddr[ADDR_W-1]));

  // R10: unlocked picture bank is the outer value
  a_r10_unlocked_chr: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (chrBank == chrOrVal));

  // R5: upper byte of the program mask stays zero
  a_r5_mask_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    prgAndMask[PRG_W-1:8] == '0);
endmodule

bind outer_bank_supervisor obs_checker #(
  .ADDR_W(ADDR_W), .PRG_W(PRG_W), .CHR_W(CHR_W), .MODE_W(VARIANT_W + 5)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuAddr   (cpuAddr),
  .locked    (locked),
  .modeIdx   (modeIdx),
  .prgAndMask(prgAndMask),
  .prgOrVal  (prgOrVal),
  .chrOrVal  (chrOrVal),
  .chrBank   (chrBank),
  .flashSel  (flashSel)
);

// File: tb/tb_outer_bank_supervisor.sv
module tb_outer_bank_supervisor;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  variant = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuData = 0;
  logic        cpuWrite = 0, cpuRead = 0;
  logic [15:0] innerPrgBank = 0;
  logic [1:0]  innerPrgShift = 0, innerChrShift = 0;
  logic [7:0]  innerChrBank = 0;
  logic        innerMirrorVert = 0;
  logic        locked, mirrorVert, chrRamWe, flashSel;
  logic [7:0]  modeIdx, chrAndMask, chrOrVal, chrBank;
  logic [15:0] prgAndMask, prgOrVal, prgBank;

  int tests = 0, fails = 0;
  int mReg [8];

  always #5 clk = ~clk;

  outer_bank_supervisor dut (.*);

  // Behavioural reference: register contents only
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mReg[i] <= 0;
    end else if (cpuWrite && mReg[0] < 128 && (cpuAddr >> 12) == 5) begin
      mReg[cpuAddr % 8] <= cpuData;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    int lk, pAnd, pOr, cAnd, cOr, pB, cB, mir, fl, sh, m;
    lk   = (mReg[0] >= 128);
    pAnd = (variant == 2) ? mReg[3] : 255 - mReg[3];
    pOr  = mReg[2] * 256 + mReg[1];
    cAnd = 255 - (((mReg[4] / 8) % 8) * 32);
    cOr  = mReg[6];
    if (!lk) begin
      case ((cpuAddr / 8192) % 4)
        0: pB = pOr;
        1: pB = (pOr + 1) % 65536;
        2: pB = (variant == 3) ? 30 : 62;
        default: pB = (variant == 3) ? 31 : 63;
      endcase
      cB  = cOr;
      mir = mReg[4] % 2;
      fl  = (cpuAddr >= 32768) && (cpuRead || cpuWrite);
    end else begin
      sh = innerPrgShift;
      m  = pAnd >> sh;
      pB = ((innerPrgBank & m) | ((pOr >> sh) & ~m)) & 65535;
      sh = innerChrShift;
      m  = cAnd >> sh;
      cB = ((innerChrBank & m) | ((cOr >> sh) & ~m)) & 255;
      mir = innerMirrorVert;
      fl  = 0;
    end
    chk("R3 locked", locked, lk);
    chk("R4 modeIdx", modeIdx, variant * 32 + mReg[0] % 32);
    chk("R5 prgAndMask", prgAndMask, pAnd);
    chk("R6 prgOrVal", prgOrVal, pOr);
    chk("R7 chrAndMask", chrAndMask, cAnd);
    chk("R7 chrOrVal", chrOrVal, cOr);
    chk("R8 chrRamWe", chrRamWe, ((mReg[5] / 4) % 2) == 0);
    chk(lk ? "R12 prgBank" : "R9 prgBank", prgBank, pB);
    chk(lk ? "R12 chrBank" : "R10 chrBank", chrBank, cB);
    chk(lk ? "R13 mirrorVert" : "R10 mirrorVert", mirrorVert, mir);
    chk("R11 flashSel", flashSel, fl);
  endtask

  task automatic step();
    #1 compareAll();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpuAddr = a; cpuData = d; cpuWrite = 1;
    step();
    cpuWrite = 0;
    step();
  endtask

  task automatic rd(input logic [15:0] a);
    cpuAddr = a; cpuRead = 1;
    step();
    cpuRead = 0;
  endtask

  task automatic doReset(input logic [2:0] v);
    rstN = 0; variant = v;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset(0);
    #1;
    chk("R1 locked after reset", locked, 0);
    chk("R1 chrRamWe after reset", chrRamWe, 1);
    chk("R1 prgAndMask after reset", prgAndMask, 16'h00FF);
    chk("R1 chrAndMask after reset", chrAndMask, 8'hFF);
    step();
    // R2: window writes with varied middle address bits
    wr(16'h5A31, 8'hFF);
    wr(16'h5002, 8'h12);
    wr(16'h5FFB, 8'h0F);
    wr(16'h5124, 8'h29);
    wr(16'h5806, 8'h47);
    chk("R2 chrOrVal after window write", chrOrVal, 8'h47);
    chk("R2 prgOrVal after window write", prgOrVal, 16'h12FF);
    // R2: outside the window is ignored
    wr(16'h4FFE, 8'hAA);
    wr(16'h6006, 8'h55);
    chk("R2 chrOrVal after outside write", chrOrVal, 8'h47);
    // R9/R11: boot slots, carry into upper byte
    for (int s = 0; s < 4; s++) rd(16'h8000 + 16'(s) * 16'h2000 + 16'h0123);
    rd(16'h4000);
    cpuAddr = 16'hC000; cpuWrite = 0; step();
    wr(16'h5005, 8'h04);
    wr(16'h5005, 8'h00);
    // R3: register 0 without bit 7 keeps unlocked
    wr(16'h5000, 8'h05);
    chk("R3 still unlocked", locked, 0);
    wr(16'h5000, 8'h83);
    chk("R3 locked after bit7", locked, 1);
    chk("R4 modeIdx locked", modeIdx, 8'h03);
    // R3: late writes ignored
    wr(16'h5001, 8'h00);
    wr(16'h5000, 8'h00);
    wr(16'h5006, 8'h00);
    chk("R3 prgOrVal frozen", prgOrVal, 16'h12FF);
    chk("R3 still locked", locked, 1);
    // R12/R13: merge across all shifts
    innerPrgBank = 16'hABCD; innerChrBank = 8'h5A;
    for (int s = 0; s < 4; s++) begin
      innerPrgShift = 2'(s); innerChrShift = 2'(3 - s);
      innerMirrorVert = s[0];
      rd(16'h8000 + 16'(s) * 16'h2000);
    end
    innerPrgBank = 16'h0F0F; innerChrBank = 8'hFF;
    for (int s = 0; s < 4; s++) begin
      innerPrgShift = 2'(s); innerChrShift = 2'(s);
      step();
    end
    // R5: variant 2 keeps register 3 as-is
    doReset(2);
    wr(16'h5003, 8'h3C);
    chk("R5 variant2 mask", prgAndMask, 16'h003C);
    // R9: variant 3 boot constants
    doReset(3);
    for (int s = 0; s < 4; s++) rd(16'hE000 - 16'(s) * 16'h2000);
    wr(16'h5004, 8'h39);
    step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule